// File: doc/BRIEF.md
# Logarithmic-Step Wiper Code Register

This block holds the wiper position of a digital potentiometer as an unsigned code. Software-level control arrives as a one-cycle command strobe with an opcode. A code can be written directly. It can be doubled, which raises the level by about 6 dB, or halved, which lowers it by about 6 dB. It can also be reloaded from one of two preset words that stand in for nonvolatile storage.

Doubling saturates in two places so that a chain of doublings follows a logarithmic curve. A zero code steps to 1 instead of staying at 0, and any code at or above midscale jumps to full scale instead of wrapping. Halving is a plain logical shift toward the LSB with zero fill.

After a restore the block reports a read-mode state. It stays there until a no-op command returns it to idle.

Top module: `logstep_wiper`

## Requirements
- R1: While `rst` is high at a rising clock edge, the wiper code takes preset word A (slot 0) and `read_mode` goes low. This is visible after that edge.
- R2: A load command (opcode 1) writes `load_val` into the wiper code exactly as given, including 0 and full scale, with no saturation.
- R3: A shift-left command (opcode 2) on code 0 gives code 1.
- R4: A shift-left command on any code at or above midscale (2^(W-1), 512 by default) gives full scale (all ones, 1023 by default).
- R5: A shift-left command on codes from 1 to midscale-1 doubles the code.
- R6: A shift-right command (opcode 3) shifts the code one place toward the LSB with zero fill, so 0 stays 0.
- R7: A restore command (opcode 4) loads preset word A when `nv_slot` is 0 and preset word B when it is 1, and sets `read_mode`.
- R8: A no-op command (opcode 0) clears `read_mode` and leaves the wiper code unchanged.
- R9: A cycle with `cmd_valid` low, or a command with an unknown opcode (5, 6 or 7), changes neither the wiper code nor `read_mode`.
- R10: Once set, `read_mode` stays high through load, shift and restore commands, and only a no-op or reset clears it.
- R11: Every command takes effect on the rising edge at which its strobe is sampled high, and the result is visible on `wiper` after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restores preset word A |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode: 0 no-op, 1 load, 2 shift left, 3 shift right, 4 restore |
| load_val | input | W (10) | Code written by a load command |
| nv_slot | input | 1 | Preset word used by a restore command |
| wiper | output | W (10) | Current wiper code |
| read_mode | output | 1 | High from a restore until the next no-op |

## Verification
The two saturation corners of the left shift get the most attention. Every one of the 1024 start codes is shifted both ways. A design that let code 0 stay at 0 would stall a doubling ramp at the bottom. A design that truncated codes at or above midscale would drop to a small value or zero instead of reaching full scale. The random phase mixes unknown opcodes and idle cycles with restores and no-ops. A design that decoded opcodes 5 to 7 as real commands would move the wiper. A design that cleared the read-mode flag on load or shift, rather than only on a no-op, would show the flag falling too early.

// File: rtl/logstep_wiper.sv
module logstep_wiper #(
  parameter int W = 10,
  parameter logic [W-1:0] PRESET_A = 10'd300,
  parameter logic [W-1:0] PRESET_B = 10'd77
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] load_val,
  input  logic         nv_slot,
  output logic [W-1:0] wiper,
  output logic         read_mode
);
  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_LD  = 3'd1;
  localparam logic [2:0] OP_SHL = 3'd2;
  localparam logic [2:0] OP_SHR = 3'd3;
  localparam logic [2:0] OP_RST = 3'd4;
  localparam logic [W-1:0] MID  = W'(1) << (W-1);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] shl_val, shr_val, nv_val;

  assign shl_val = (wiper == '0)  ? W'(1) :
                   (wiper >= MID) ? FULL  : {wiper[W-2:0], 1'b0};
  assign shr_val = {1'b0, wiper[W-1:1]};
  assign nv_val  = nv_slot ? PRESET_B : PRESET_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper     <= PRESET_A;
      read_mode <= 1'b0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_NOP: read_mode <= 1'b0;
        OP_LD:  wiper <= load_val;
        OP_SHL: wiper <= shl_val;
        OP_SHR: wiper <= shr_val;
        OP_RST: begin
          wiper     <= nv_val;
          read_mode <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/logstep_wiper_chk.sv
module logstep_wiper_chk #(
  parameter int W = 10,
  parameter logic [W-1:0] PRESET_A = 10'd300,
  parameter logic [W-1:0] PRESET_B = 10'd77
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic [W-1:0] load_val,
  input logic         nv_slot,
  input logic [W-1:0] wiper,
  input logic         read_mode
);
  localparam logic [W-1:0] MID  = W'(1) << (W-1);
  localparam logic [W-1:0] FULL = '1;

  a_r1_reset_preset: assert property (@(posedge clk)
    rst |=> (wiper == PRESET_A && !read_mode));

  a_r2_load_exact: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1) |=> wiper == $past(load_val));

  a_r3_shl_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && wiper == '0) |=> wiper == W'(1));

  a_r4_shl_saturate: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && wiper >= MID) |=> wiper == FULL);

  a_r6_shr_halve: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd3) |=> wiper == ($past(wiper) >> 1));

  a_r7_restore_mode: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd4) |=>
      (read_mode && wiper == ($past(nv_slot) ? PRESET_B : PRESET_A)));

  a_r8_nop_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd0) |=> (!read_mode && $stable(wiper)));

  a_r9_no_cmd: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid || cmd_op > 3'd4) |=> ($stable(wiper) && $stable(read_mode)));

  a_r10_mode_sticky: assert property (@(posedge clk) disable iff (rst)
    (read_mode && !(cmd_valid && cmd_op == 3'd0)) |=> read_mode);
endmodule

bind logstep_wiper logstep_wiper_chk #(.W(W), .PRESET_A(PRESET_A), .PRESET_B(PRESET_B)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .load_val(load_val), .nv_slot(nv_slot), .wiper(wiper), .read_mode(read_mode)
);

// File: tb/logstep_wiper_tb_top.sv
module logstep_wiper_tb_top;
  localparam int CLK_P = 10;
  localparam logic [9:0] PA = 10'd300;
  localparam logic [9:0] PB = 10'd77;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0, nv_slot = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [9:0] load_val = '0;
  logic [9:0] wiper;
  logic read_mode;
  int n_chk = 0, n_fail = 0;
  logic [9:0] m_w;
  logic m_rm;

  always #(CLK_P/2) clk = ~clk;

  logstep_wiper #(.W(10), .PRESET_A(PA), .PRESET_B(PB)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .load_val(load_val), .nv_slot(nv_slot), .wiper(wiper), .read_mode(read_mode));

  function automatic logic [9:0] ref_shl(input logic [9:0] c);
    if (c == 10'd0) return 10'd1;
    if (c >= 10'd512) return 10'd1023;
    return c * 2;
  endfunction

  function automatic logic [9:0] ref_shr(input logic [9:0] c);
    return c / 2;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  // Drive at the falling edge; the result is sampled one falling edge later.
  task automatic cmd(input logic v, input logic [2:0] op, input logic [9:0] val, input logic s);
    cmd_valid = v; cmd_op = op; load_val = val; nv_slot = s;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic model(input logic v, input logic [2:0] op, input logic [9:0] val, input logic s);
    if (!v) return;
    case (op)
      3'd0: m_rm = 1'b0;
      3'd1: m_w = val;
      3'd2: m_w = ref_shl(m_w);
      3'd3: m_w = ref_shr(m_w);
      3'd4: begin m_w = s ? PB : PA; m_rm = 1'b1; end
      default: ;
    endcase
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset wiper", wiper, PA);
    check("R1 reset read_mode", read_mode, 0);

    // R11: sample the result one falling edge after the strobe edge
    cmd(1'b1, 3'd1, 10'd1023, 1'b0); check("R2 load full scale", wiper, 1023);
    check("R11 same-edge effect", wiper, 1023);
    cmd(1'b1, 3'd1, 10'd0, 1'b0);    check("R2 load zero", wiper, 0);

    // R3 R5 R4: doubling ramp from 0
    begin
      logic [9:0] e;
      e = 10'd0;
      for (int i = 0; i < 13; i++) begin
        cmd(1'b1, 3'd2, 10'd0, 1'b0);
        e = ref_shl(e);
        check("R3/R4/R5 shl ramp", wiper, e);
      end
      for (int i = 0; i < 12; i++) begin
        cmd(1'b1, 3'd3, 10'd0, 1'b0);
        e = ref_shr(e);
        check("R6 shr ramp", wiper, e);
      end
    end

    // Exhaustive shift over all start codes
    for (int c = 0; c < 1024; c++) begin
      cmd(1'b1, 3'd1, 10'(c), 1'b0);
      cmd(1'b1, 3'd2, 10'd0, 1'b0);
      if (c == 0) check("R3 shl zero", wiper, 1);
      else if (c >= 512) check("R4 shl saturate", wiper, 1023);
      else check("R5 shl double", wiper, int'(ref_shl(10'(c))));
      cmd(1'b1, 3'd1, 10'(c), 1'b0);
      cmd(1'b1, 3'd3, 10'd0, 1'b0);
      check("R6 shr", wiper, int'(ref_shr(10'(c))));
    end

    // R7 R10 R8 directed
    cmd(1'b1, 3'd4, 10'd0, 1'b1);
    check("R7 restore slot B", wiper, PB); check("R7 read_mode set", read_mode, 1);
    cmd(1'b1, 3'd2, 10'd0, 1'b0);
    check("R10 mode held after shl", read_mode, 1);
    cmd(1'b1, 3'd1, 10'd5, 1'b0);
    check("R10 mode held after load", read_mode, 1);
    cmd(1'b1, 3'd6, 10'd900, 1'b0);
    check("R9 unknown op wiper", wiper, 5); check("R9 unknown op mode", read_mode, 1);
    cmd(1'b0, 3'd1, 10'd900, 1'b0);
    check("R9 no strobe wiper", wiper, 5);
    cmd(1'b1, 3'd0, 10'd900, 1'b0);
    check("R8 nop clears mode", read_mode, 0); check("R8 nop keeps wiper", wiper, 5);
    cmd(1'b1, 3'd4, 10'd0, 1'b0);
    check("R7 restore slot A", wiper, PA);

    // Random mix against model
    m_w = wiper; m_rm = read_mode;
    for (int i = 0; i < 4000; i++) begin
      logic v, s;
      logic [2:0] op;
      logic [9:0] val;
      v = ($urandom % 8) != 0;
      op = 3'($urandom % 8);
      val = ($urandom % 4 == 0) ? (($urandom % 2) ? 10'd0 : 10'd1023) : 10'($urandom);
      s = 1'($urandom);
      cmd(v, op, val, s);
      model(v, op, val, s);
      check("R9/R10 random wiper", wiper, m_w);
      check("R8/R10 random read_mode", read_mode, m_rm);
    end

    // R1 reset mid-run
    cmd(1'b1, 3'd4, 10'd0, 1'b1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 reset again wiper", wiper, PA);
    check("R1 reset again mode", read_mode, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule